// File: doc/BRIEF.md
# Priority-Based Peripheral Pin Crossbar

This block places a fixed set of peripheral signals onto a bank of general-purpose pins. The peripherals are a UART, an SPI port, a two-wire open-drain bus and two timer outputs. A configuration word is captured into registers on a load strobe. It holds a global enable, one routing enable per peripheral, the SPI wire mode, a per-pin skip mask and a per-pin push-pull mask. From these registers the block works out combinationally which pin each function owns.

The UART has two fixed pins that are reserved before anything else is placed. The other functions are then packed in a fixed priority order onto the lowest pins that are neither skipped nor reserved: SPI clock, SPI MISO, SPI MOSI, SPI slave select (only in 4-wire mode), two-wire data and clock as one pair, timer 0 and timer 1. Pins that no function claims carry the general-purpose output and output enable. For every pin the block drives the output value, the output enable and an open-drain flag. It also sends the pin inputs back to the functions that own them.

Top module: `pin_crossbar`

## Requirements
- R1: On a rising clock edge with `cfg_load` high, all `cfg_*` inputs are captured, and the outputs follow the new settings from that edge on. Without `cfg_load` the captured settings do not change. After reset every enable is 0 and the skip and push-pull masks are 0.
- R2: While the captured global enable is 0, every bit of `pin_oe` is 0 and every bit of `func_in` is 1, whatever the other settings and inputs are.
- R3: With the UART enabled, the UART TX function (index 0) is on pin 4 and the UART RX function (index 1) is on pin 5, even when those pins are skipped. No packed function is placed on either pin. With the UART disabled, pins 4 and 5 are free for packing.
- R4: Packed functions are placed in the order SPI clock (index 2), MISO (3), MOSI (4), slave select (5), two-wire data (6), two-wire clock (7), timer 0 (8), timer 1 (9). Each enabled function takes the lowest-numbered pin that is free, not skipped and not reserved. No pin is given to two functions.
- R5: `cfg_spi_mode` = 2'b00 selects 3-wire mode, and the slave select is not routed. Any other value selects 4-wire mode, and the slave select takes the next free pin after MOSI, which moves every lower-priority function up by one free pin.
- R6: The two-wire data and clock are placed together on the two lowest free pins, or not at all. If fewer than two pins are free, both stay unrouted, and the timer outputs below them are still packed onto whatever pins remain.
- R7: The pins set in the parameter `FORCED_SKIP` (default pin 12) are treated as skipped whatever `cfg_skip` holds.
- R8: `func_unplaced[f]` is 1 exactly when function f is requested and has no pin. The UART bits (0 and 1) are always 0.
- R9: A pin that no function owns drives `gpio_out` on `pin_out` and `gpio_oe` (gated by the global enable) on `pin_oe`. An owned pin drives the owner's `func_out` and `func_oe` bits.
- R10: `pin_od` is 1 on the two-wire data and clock pins. On every other pin it is the inverse of the captured push-pull bit.
- R11: `func_in[f]` equals `pin_in` at the pin that function f owns, if the global enable is 1. Otherwise, or if f has no pin, it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Capture strobe for all configuration inputs |
| cfg_xbar_en | input | 1 | Global crossbar enable |
| cfg_uart_en | input | 1 | UART routing enable |
| cfg_spi_en | input | 1 | SPI routing enable |
| cfg_spi_mode | input | 2 | SPI wire mode, 2'b00 = 3-wire, else 4-wire |
| cfg_twi_en | input | 1 | Two-wire bus routing enable |
| cfg_tmr0_en | input | 1 | Timer 0 output routing enable |
| cfg_tmr1_en | input | 1 | Timer 1 output routing enable |
| cfg_skip | input | NUM_PINS | Pins excluded from packing |
| cfg_pushpull | input | NUM_PINS | Per-pin push-pull select, 0 = open drain |
| func_out | input | 10 | Output value of each function, by function index |
| func_oe | input | 10 | Output enable of each function |
| func_in | output | 10 | Pin value routed back to each function |
| func_unplaced | output | 10 | Function requested but not given a pin |
| gpio_out | input | NUM_PINS | General-purpose output value per pin |
| gpio_oe | input | NUM_PINS | General-purpose output enable per pin |
| pin_in | input | NUM_PINS | Pad input value per pin |
| pin_out | output | NUM_PINS | Pad output value per pin |
| pin_oe | output | NUM_PINS | Pad output enable per pin |
| pin_od | output | NUM_PINS | Pad open-drain flag per pin |

## Verification
The hardest case to reach is a shortage of pins: a skip mask that leaves exactly one free pin when the two-wire pair comes up, or none for the last functions. Only that case shows that the pair is placed atomically and that lower-priority functions keep packing. A table of hand-worked configurations builds these masks on purpose, together with the 3-wire and 4-wire shift and the forced-skip pin. A long run of random enables, sparse skip masks and SPI modes then compares every output against an independent placement model.

// File: rtl/pin_crossbar_pkg.sv
// Shared definitions for the pin crossbar: function indices in priority
// order and the captured routing-enable register layout.
package pin_crossbar_pkg;

    localparam int NUM_FUNC     = 10;
    localparam int FUNC_W       = $clog2(NUM_FUNC);
    localparam int F_UTX        = 0;
    localparam int F_URX        = 1;
    localparam int F_SCK        = 2;
    localparam int F_MISO       = 3;
    localparam int F_MOSI       = 4;
    localparam int F_NSS        = 5;
    localparam int F_SDA        = 6;
    localparam int F_SCL        = 7;
    localparam int F_TM0        = 8;
    localparam int F_TM1        = 9;
    localparam int FIRST_PACKED = F_SCK;

    typedef struct packed {
        logic       xbar_en;
        logic       uart_en;
        logic       spi_en;
        logic [1:0] spi_mode;
        logic       twi_en;
        logic       tm0_en;
        logic       tm1_en;
    } route_cfg_t;

    // True when the SPI mode field selects the 4-wire variant.
    function automatic logic spi_four_wire(input logic [1:0] mode);
        return mode != 2'b00;
    endfunction

endpackage

// File: rtl/xbar_cfg_regs.sv
// Configuration storage for the crossbar: routing enables, skip mask and
// push-pull mask, all loaded together on one strobe.
// Assumes: rst_n is synchronous and active low.
module xbar_cfg_regs
    import pin_crossbar_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  route_cfg_t          route_d,
    input  logic [NUM_PINS-1:0] skip_d,
    input  logic [NUM_PINS-1:0] pp_d,
    output route_cfg_t          route_q,
    output logic [NUM_PINS-1:0] skip_q,
    output logic [NUM_PINS-1:0] pp_q
);

    // Routing-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)    route_q <= '0;
        else if (load) route_q <= route_d;
    end

    // Skip-mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)    skip_q <= '0;
        else if (load) skip_q <= skip_d;
    end

    // Drive-mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)    pp_q <= '0;
        else if (load) pp_q <= pp_d;
    end

endmodule

// File: rtl/xbar_allocator.sv
// Priority packer: reserves the fixed UART pins, then gives each requested
// function the lowest free pin in priority order. The two-wire pair is
// placed atomically on the two lowest free pins.
// Assumes: fixed pin numbers are below NUM_PINS and differ from each other.
module xbar_allocator
    import pin_crossbar_pkg::*;
#(
    parameter int                    NUM_PINS    = 16,
    parameter int                    UTX_PIN     = 4,
    parameter int                    URX_PIN     = 5,
    parameter logic [NUM_PINS-1:0]   FORCED_SKIP = '0,
    localparam int                   PIN_W       = $clog2(NUM_PINS)
) (
    input  logic                             uart_en,
    input  logic                             spi_en,
    input  logic [1:0]                       spi_mode,
    input  logic                             twi_en,
    input  logic                             tm0_en,
    input  logic                             tm1_en,
    input  logic [NUM_PINS-1:0]              skip,
    output logic [NUM_PINS-1:0]              skip_eff,
    output logic [NUM_FUNC-1:0][PIN_W-1:0]   func_pos,
    output logic [NUM_FUNC-1:0]              func_placed,
    output logic [NUM_FUNC-1:0]              func_unplaced
);

    localparam logic [NUM_PINS-1:0] FIXED_MASK =
        (NUM_PINS'(1) << UTX_PIN) | (NUM_PINS'(1) << URX_PIN);

    logic [NUM_FUNC-1:0] request;
    logic [NUM_PINS-1:0] free;
    logic [PIN_W:0]      first;
    logic [PIN_W:0]      second;

    // Lowest set bit of a mask, with a found flag in the top bit.
    function automatic logic [PIN_W:0] lowest_free(input logic [NUM_PINS-1:0] m);
        logic [PIN_W:0] r;
        r = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (m[i]) r = {1'b1, PIN_W'(i)};
        end
        return r;
    endfunction

    assign skip_eff = skip | FORCED_SKIP;

    // Which packed functions the enables ask for.
    always_comb begin
        request          = '0;
        request[F_SCK]   = spi_en;
        request[F_MISO]  = spi_en;
        request[F_MOSI]  = spi_en;
        request[F_NSS]   = spi_en && spi_four_wire(spi_mode);
        request[F_SDA]   = twi_en;
        request[F_SCL]   = twi_en;
        request[F_TM0]   = tm0_en;
        request[F_TM1]   = tm1_en;
    end

    // Walk functions in priority order, consuming free pins.
    always_comb begin
        free        = ~skip_eff;
        func_pos    = '0;
        func_placed = '0;
        first       = '0;
        second      = '0;
        if (uart_en) begin
            free                = free & ~FIXED_MASK;
            func_pos[F_UTX]     = PIN_W'(UTX_PIN);
            func_pos[F_URX]     = PIN_W'(URX_PIN);
            func_placed[F_UTX]  = 1'b1;
            func_placed[F_URX]  = 1'b1;
        end
        for (int f = FIRST_PACKED; f < NUM_FUNC; f++) begin
            if (request[f] && f != F_SCL) begin
                first  = lowest_free(free);
                second = lowest_free(free & ~(NUM_PINS'(first[PIN_W]) << first[PIN_W-1:0]));
                if (f == F_SDA) begin
                    if (first[PIN_W] && second[PIN_W]) begin
                        func_pos[F_SDA]           = first[PIN_W-1:0];
                        func_pos[F_SCL]           = second[PIN_W-1:0];
                        func_placed[F_SDA]        = 1'b1;
                        func_placed[F_SCL]        = 1'b1;
                        free[first[PIN_W-1:0]]    = 1'b0;
                        free[second[PIN_W-1:0]]   = 1'b0;
                    end
                end else if (first[PIN_W]) begin
                    func_pos[f]            = first[PIN_W-1:0];
                    func_placed[f]         = 1'b1;
                    free[first[PIN_W-1:0]] = 1'b0;
                end
            end
        end
    end

    assign func_unplaced = request & ~func_placed;

endmodule

// File: rtl/xbar_pin_mux.sv
// Per-pin output selection: the owning function or the GPIO source drives
// value and enable; the global enable gates every output enable, and
// two-wire pins are forced open drain.
// Assumes: at most one placed function per pin (guaranteed by the packer).
module xbar_pin_mux
    import pin_crossbar_pkg::*;
#(
    parameter int  NUM_PINS = 16,
    localparam int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic                           xbar_en,
    input  logic [NUM_FUNC-1:0][PIN_W-1:0] func_pos,
    input  logic [NUM_FUNC-1:0]            func_placed,
    input  logic [NUM_FUNC-1:0]            func_out,
    input  logic [NUM_FUNC-1:0]            func_oe,
    input  logic [NUM_PINS-1:0]            gpio_out,
    input  logic [NUM_PINS-1:0]            gpio_oe,
    input  logic [NUM_PINS-1:0]            pushpull,
    output logic [NUM_PINS-1:0]            pin_out,
    output logic [NUM_PINS-1:0]            pin_oe,
    output logic [NUM_PINS-1:0]            pin_od
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic owned;
        logic sel_out;
        logic sel_oe;
        logic twi_pin;

        // Find the function, if any, that owns this pin.
        always_comb begin
            owned   = 1'b0;
            sel_out = 1'b0;
            sel_oe  = 1'b0;
            twi_pin = 1'b0;
            for (int f = 0; f < NUM_FUNC; f++) begin
                if (func_placed[f] && func_pos[f] == PIN_W'(p)) begin
                    owned   = 1'b1;
                    sel_out = func_out[f];
                    sel_oe  = func_oe[f];
                    twi_pin = (f == F_SDA) || (f == F_SCL);
                end
            end
        end

        assign pin_out[p] = owned ? sel_out : gpio_out[p];
        assign pin_oe[p]  = xbar_en && (owned ? sel_oe : gpio_oe[p]);
        assign pin_od[p]  = twi_pin || !pushpull[p];
    end

endmodule

// File: rtl/xbar_in_route.sv
// Input return path: each placed function reads its own pin while the
// crossbar is enabled; otherwise it sees an idle-high level.
// Assumes: func_pos is only meaningful where func_placed is set.
module xbar_in_route
    import pin_crossbar_pkg::*;
#(
    parameter int  NUM_PINS = 16,
    localparam int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic                           xbar_en,
    input  logic [NUM_FUNC-1:0][PIN_W-1:0] func_pos,
    input  logic [NUM_FUNC-1:0]            func_placed,
    input  logic [NUM_PINS-1:0]            pin_in,
    output logic [NUM_FUNC-1:0]            func_in
);

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
        assign func_in[f] = (xbar_en && func_placed[f]) ? pin_in[func_pos[f]] : 1'b1;
    end

endmodule

// File: rtl/pin_crossbar.sv
// Top of the peripheral pin crossbar: registered configuration, priority
// packer, per-pin output mux and input return path.
// Assumes: synchronous active-low reset; outputs are combinational from the
// configuration registers and the live function/GPIO/pin inputs.
module pin_crossbar
    import pin_crossbar_pkg::*;
#(
    parameter int                  NUM_PINS    = 16,
    parameter int                  UTX_PIN     = 4,
    parameter int                  URX_PIN     = 5,
    parameter logic [NUM_PINS-1:0] FORCED_SKIP = NUM_PINS'(16'h1000)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_load,
    input  logic                cfg_xbar_en,
    input  logic                cfg_uart_en,
    input  logic                cfg_spi_en,
    input  logic [1:0]          cfg_spi_mode,
    input  logic                cfg_twi_en,
    input  logic                cfg_tmr0_en,
    input  logic                cfg_tmr1_en,
    input  logic [NUM_PINS-1:0] cfg_skip,
    input  logic [NUM_PINS-1:0] cfg_pushpull,
    input  logic [9:0]          func_out,
    input  logic [9:0]          func_oe,
    output logic [9:0]          func_in,
    output logic [9:0]          func_unplaced,
    input  logic [NUM_PINS-1:0] gpio_out,
    input  logic [NUM_PINS-1:0] gpio_oe,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_od
);

    localparam int PIN_W = $clog2(NUM_PINS);

    route_cfg_t                     route_d;
    route_cfg_t                     route_q;
    logic [NUM_PINS-1:0]            skip_q;
    logic [NUM_PINS-1:0]            pushpull_q;
    logic [NUM_PINS-1:0]            skip_eff;
    logic [NUM_FUNC-1:0][PIN_W-1:0] func_pos;
    logic [NUM_FUNC-1:0]            func_placed;

    // Gather the configuration inputs into the register layout.
    always_comb begin
        route_d.xbar_en  = cfg_xbar_en;
        route_d.uart_en  = cfg_uart_en;
        route_d.spi_en   = cfg_spi_en;
        route_d.spi_mode = cfg_spi_mode;
        route_d.twi_en   = cfg_twi_en;
        route_d.tm0_en   = cfg_tmr0_en;
        route_d.tm1_en   = cfg_tmr1_en;
    end

    xbar_cfg_regs #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cfg_load),
        .route_d (route_d),
        .skip_d  (cfg_skip),
        .pp_d    (cfg_pushpull),
        .route_q (route_q),
        .skip_q  (skip_q),
        .pp_q    (pushpull_q)
    );

    xbar_allocator #(
        .NUM_PINS    (NUM_PINS),
        .UTX_PIN     (UTX_PIN),
        .URX_PIN     (URX_PIN),
        .FORCED_SKIP (FORCED_SKIP)
    ) u_alloc (
        .uart_en       (route_q.uart_en),
        .spi_en        (route_q.spi_en),
        .spi_mode      (route_q.spi_mode),
        .twi_en        (route_q.twi_en),
        .tm0_en        (route_q.tm0_en),
        .tm1_en        (route_q.tm1_en),
        .skip          (skip_q),
        .skip_eff      (skip_eff),
        .func_pos      (func_pos),
        .func_placed   (func_placed),
        .func_unplaced (func_unplaced)
    );

    xbar_pin_mux #(.NUM_PINS(NUM_PINS)) u_mux (
        .xbar_en     (route_q.xbar_en),
        .func_pos    (func_pos),
        .func_placed (func_placed),
        .func_out    (func_out),
        .func_oe     (func_oe),
        .gpio_out    (gpio_out),
        .gpio_oe     (gpio_oe),
        .pushpull    (pushpull_q),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .pin_od      (pin_od)
    );

    xbar_in_route #(.NUM_PINS(NUM_PINS)) u_in (
        .xbar_en     (route_q.xbar_en),
        .func_pos    (func_pos),
        .func_placed (func_placed),
        .pin_in      (pin_in),
        .func_in     (func_in)
    );

endmodule

// File: rtl/pin_crossbar_chk.sv
// Assertion checker for the pin crossbar, bound into every instance.
// Assumes: sees the captured configuration and the packer outputs.
module pin_crossbar_chk
    import pin_crossbar_pkg::*;
#(
    parameter int                  NUM_PINS    = 16,
    parameter int                  UTX_PIN     = 4,
    parameter int                  URX_PIN     = 5,
    parameter logic [NUM_PINS-1:0] FORCED_SKIP = '0,
    localparam int                 PIN_W       = $clog2(NUM_PINS)
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cfg_load,
    input logic                           xbar_en,
    input logic                           uart_en,
    input logic [1:0]                     spi_mode,
    input route_cfg_t                     route_q,
    input logic [NUM_PINS-1:0]            skip_q,
    input logic [NUM_PINS-1:0]            pushpull_q,
    input logic [NUM_PINS-1:0]            skip_eff,
    input logic [NUM_FUNC-1:0][PIN_W-1:0] func_pos,
    input logic [NUM_FUNC-1:0]            func_placed,
    input logic [NUM_FUNC-1:0]            func_unplaced,
    input logic [NUM_PINS-1:0]            pin_oe,
    input logic [NUM_PINS-1:0]            pin_od
);

    logic [NUM_PINS-1:0] claim;

    // Pins claimed by packed functions.
    always_comb begin
        claim = '0;
        for (int f = FIRST_PACKED; f < NUM_FUNC; f++) begin
            if (func_placed[f]) claim[func_pos[f]] = 1'b1;
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(route_q) && $stable(skip_q) && $stable(pushpull_q)); // R1
    AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !xbar_en |-> pin_oe == '0); // R2
    AST_UART_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        uart_en |-> func_placed[F_UTX] && func_placed[F_URX] &&
                    func_pos[F_UTX] == PIN_W'(UTX_PIN) && func_pos[F_URX] == PIN_W'(URX_PIN)); // R3
    AST_FIXED_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        uart_en |-> !claim[UTX_PIN] && !claim[URX_PIN]); // R3
    AST_NO_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(claim) == $countones(func_placed[NUM_FUNC-1:FIRST_PACKED])); // R4
    AST_SKIP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (claim & skip_eff) == '0); // R4
    AST_NSS_3WIRE: assert property (@(posedge clk) disable iff (!rst_n)
        spi_mode == 2'b00 |-> !func_placed[F_NSS]); // R5
    AST_TWI_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        func_placed[F_SDA] == func_placed[F_SCL]); // R6
    AST_FORCED_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (claim & FORCED_SKIP) == '0); // R7
    AST_UART_NEVER_UNPLACED: assert property (@(posedge clk) disable iff (!rst_n)
        func_unplaced[F_URX:F_UTX] == 2'b00); // R8
    AST_TWI_OD: assert property (@(posedge clk) disable iff (!rst_n)
        func_placed[F_SDA] |-> pin_od[func_pos[F_SDA]] && pin_od[func_pos[F_SCL]]); // R10

endmodule

bind pin_crossbar pin_crossbar_chk #(
    .NUM_PINS    (NUM_PINS),
    .UTX_PIN     (UTX_PIN),
    .URX_PIN     (URX_PIN),
    .FORCED_SKIP (FORCED_SKIP)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_load      (cfg_load),
    .xbar_en       (route_q.xbar_en),
    .uart_en       (route_q.uart_en),
    .spi_mode      (route_q.spi_mode),
    .route_q       (route_q),
    .skip_q        (skip_q),
    .pushpull_q    (pushpull_q),
    .skip_eff      (skip_eff),
    .func_pos      (func_pos),
    .func_placed   (func_placed),
    .func_unplaced (func_unplaced),
    .pin_oe        (pin_oe),
    .pin_od        (pin_od)
);

// File: tb/pin_crossbar_test.sv
module pin_crossbar_test;
    import pin_crossbar_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 16;
    localparam int NF         = NUM_FUNC;
    localparam int NONE       = 31;
    localparam int NVEC       = 8;

    // uart, spi, mode[2], twi, tm0, tm1, skip[16], then positions of
    // SCK, MISO, MOSI, NSS, SDA, SCL, TM0, TM1 (31 = no pin)
    localparam logic [62:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 16'h0000,
         5'd0, 5'd1, 5'd2, 5'd31, 5'd3, 5'd6, 5'd7, 5'd8},
        {1'b1, 1'b1, 2'b01, 1'b1, 1'b1, 1'b1, 16'h0000,
         5'd0, 5'd1, 5'd2, 5'd3, 5'd6, 5'd7, 5'd8, 5'd9},
        {1'b0, 1'b1, 2'b10, 1'b1, 1'b1, 1'b1, 16'h0003,
         5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9},
        {1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 16'h00FF,
         5'd31, 5'd31, 5'd31, 5'd31, 5'd31, 5'd31, 5'd31, 5'd8},
        {1'b1, 1'b1, 2'b11, 1'b1, 1'b1, 1'b1, 16'hEFCF,
         5'd31, 5'd31, 5'd31, 5'd31, 5'd31, 5'd31, 5'd31, 5'd31},
        {1'b1, 1'b1, 2'b11, 1'b1, 1'b1, 1'b1, 16'hEF0F,
         5'd6, 5'd7, 5'd31, 5'd31, 5'd31, 5'd31, 5'd31, 5'd31},
        {1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 16'hEFBF,
         5'd31, 5'd31, 5'd31, 5'd31, 5'd31, 5'd31, 5'd6, 5'd31},
        {1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 16'h0FFF,
         5'd31, 5'd31, 5'd31, 5'd31, 5'd13, 5'd14, 5'd15, 5'd31}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic          cfg_xbar_en = 1'b0;
    logic          cfg_uart_en = 1'b0;
    logic          cfg_spi_en = 1'b0;
    logic [1:0]    cfg_spi_mode = 2'b00;
    logic          cfg_twi_en = 1'b0;
    logic          cfg_tmr0_en = 1'b0;
    logic          cfg_tmr1_en = 1'b0;
    logic [NP-1:0] cfg_skip = '0;
    logic [NP-1:0] cfg_pushpull = '0;
    logic [NF-1:0] func_out = '0;
    logic [NF-1:0] func_oe = '0;
    logic [NF-1:0] func_in;
    logic [NF-1:0] func_unplaced;
    logic [NP-1:0] gpio_out = '0;
    logic [NP-1:0] gpio_oe = '0;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic [NP-1:0] pin_od;

    int            checks = 0;
    int            errors = 0;
    int            mpos [NF];
    logic          m_xbar = 1'b0;
    logic [NP-1:0] m_pp = '0;
    logic [NF-1:0] m_req = '0;

    pin_crossbar uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_xbar_en(cfg_xbar_en), .cfg_uart_en(cfg_uart_en), .cfg_spi_en(cfg_spi_en),
        .cfg_spi_mode(cfg_spi_mode), .cfg_twi_en(cfg_twi_en), .cfg_tmr0_en(cfg_tmr0_en),
        .cfg_tmr1_en(cfg_tmr1_en), .cfg_skip(cfg_skip), .cfg_pushpull(cfg_pushpull),
        .func_out(func_out), .func_oe(func_oe), .func_in(func_in),
        .func_unplaced(func_unplaced), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check_val(input string req, input string what,
                             input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // Requests implied by the current configuration inputs.
    task automatic model_req();
        m_req         = '0;
        m_req[F_SCK]  = cfg_spi_en;
        m_req[F_MISO] = cfg_spi_en;
        m_req[F_MOSI] = cfg_spi_en;
        m_req[F_NSS]  = cfg_spi_en && (cfg_spi_mode != 2'b00);
        m_req[F_SDA]  = cfg_twi_en;
        m_req[F_SCL]  = cfg_twi_en;
        m_req[F_TM0]  = cfg_tmr0_en;
        m_req[F_TM1]  = cfg_tmr1_en;
    endtask

    // Independent placement model working from the configuration inputs.
    task automatic model_map();
        logic [NP-1:0] taken;
        taken = cfg_skip | 16'h1000;
        for (int f = 0; f < NF; f++) mpos[f] = -1;
        model_req();
        if (cfg_uart_en) begin
            mpos[F_UTX] = 4;
            mpos[F_URX] = 5;
            taken[4] = 1'b1;
            taken[5] = 1'b1;
        end
        for (int f = FIRST_PACKED; f < NF; f++) begin
            int need;
            int n;
            int got [2];
            need = (f == F_SDA) ? 2 : 1;
            n = 0;
            got[0] = 0;
            got[1] = 0;
            if (m_req[f] && f != F_SCL) begin
                for (int p = 0; p < NP; p++) begin
                    if (!taken[p] && n < need) begin
                        got[n] = p;
                        n++;
                    end
                end
                if (n == need) begin
                    mpos[f] = got[0];
                    taken[got[0]] = 1'b1;
                    if (need == 2) begin
                        mpos[F_SCL] = got[1];
                        taken[got[1]] = 1'b1;
                    end
                end
            end
        end
    endtask

    // Load the configuration inputs; outputs follow after the capturing edge.
    task automatic load_cfg();
        @(negedge clk);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 0;
        m_xbar = cfg_xbar_en;
        m_pp   = cfg_pushpull;
    endtask

    // Apply two data patterns and compare every output against the model.
    task automatic check_map(input string req);
        logic [NP-1:0] e_out;
        logic [NP-1:0] e_oe;
        logic [NP-1:0] e_od;
        logic [NF-1:0] e_in;
        logic [NF-1:0] e_unpl;
        for (int k = 0; k < 2; k++) begin
            func_out = NF'($urandom);
            func_oe  = NF'($urandom);
            gpio_out = NP'($urandom);
            gpio_oe  = NP'($urandom);
            pin_in   = NP'($urandom);
            #1;
            e_out  = gpio_out;
            e_oe   = m_xbar ? gpio_oe : '0;
            e_od   = ~m_pp;
            e_in   = '1;
            e_unpl = '0;
            for (int f = 0; f < NF; f++) begin
                if (mpos[f] >= 0) begin
                    e_out[mpos[f]] = func_out[f];
                    e_oe[mpos[f]]  = m_xbar & func_oe[f];
                    e_od[mpos[f]]  = (f == F_SDA || f == F_SCL) ? 1'b1 : ~m_pp[mpos[f]];
                    if (m_xbar) e_in[f] = pin_in[mpos[f]];
                end else if (m_req[f]) begin
                    e_unpl[f] = 1'b1;
                end
            end
            check_val(req, "R9 pin_out", 32'(pin_out), 32'(e_out));
            check_val(req, "R9 pin_oe", 32'(pin_oe), 32'(e_oe));
            check_val(req, "R10 pin_od", 32'(pin_od), 32'(e_od));
            check_val(req, "R11 func_in", 32'(func_in), 32'(e_in));
            check_val(req, "R8 func_unplaced", 32'(func_unplaced), 32'(e_unpl));
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state - nothing routed, outputs disabled, inputs idle high
        for (int f = 0; f < NF; f++) mpos[f] = -1;
        m_req = '0;
        m_xbar = 1'b0;
        m_pp = '0;
        check_map("R1 reset");

        // Table of hand-worked placements (R4 R5 R6 R7)
        for (int v = 0; v < NVEC; v++) begin
            cfg_xbar_en  = 1'b1;
            cfg_uart_en  = VEC[v][62];
            cfg_spi_en   = VEC[v][61];
            cfg_spi_mode = VEC[v][60:59];
            cfg_twi_en   = VEC[v][58];
            cfg_tmr0_en  = VEC[v][57];
            cfg_tmr1_en  = VEC[v][56];
            cfg_skip     = VEC[v][55:40];
            cfg_pushpull = NP'($urandom);
            load_cfg();
            model_req();
            for (int f = 0; f < NF; f++) mpos[f] = -1;
            if (cfg_uart_en) begin
                mpos[F_UTX] = 4;
                mpos[F_URX] = 5;
            end
            for (int f = FIRST_PACKED; f < NF; f++) begin
                int p;
                p = int'(VEC[v][39 - 5 * (f - FIRST_PACKED) -: 5]);
                if (p != NONE) mpos[f] = p;
            end
            check_map("R4 R5 R6 R7 table");
        end

        // R2: global enable off with everything requested
        cfg_xbar_en = 1'b0; cfg_uart_en = 1'b1; cfg_spi_en = 1'b1; cfg_spi_mode = 2'b01;
        cfg_twi_en = 1'b1; cfg_tmr0_en = 1'b1; cfg_tmr1_en = 1'b1;
        cfg_skip = '0; cfg_pushpull = '1;
        load_cfg();
        model_map();
        check_map("R2 disabled");
        func_oe = '1; gpio_oe = '1; pin_in = '0;
        #1;
        check_val("R2", "pin_oe all enables high", 32'(pin_oe), 32'h0);
        check_val("R2", "func_in idle", 32'(func_in), 32'h3FF);

        // R1: inputs change without a load strobe - map must not move
        @(negedge clk);
        cfg_xbar_en = 1'b1; cfg_uart_en = 1'b0; cfg_spi_en = 1'b0; cfg_skip = 16'hFFFF;
        repeat (3) @(negedge clk);
        check_map("R1 hold");

        // R3: UART pins held even when every pin is skipped
        cfg_xbar_en = 1'b1; cfg_uart_en = 1'b1; cfg_spi_en = 1'b1; cfg_spi_mode = 2'b00;
        cfg_twi_en = 1'b0; cfg_tmr0_en = 1'b0; cfg_tmr1_en = 1'b0;
        cfg_skip = 16'hFFFF; cfg_pushpull = 16'h0030;
        load_cfg();
        model_map();
        check_map("R3 fixed");
        func_out = 10'b0000000001; func_oe = 10'b0000000011;
        #1;
        check_val("R3", "tx pin out", 32'(pin_out[4]), 32'h1);
        check_val("R3", "pin_oe fixed only", 32'(pin_oe & 16'h0030), 32'h0030);

        // Random configurations against the model (R4 R5 R6 R8 R9 R10 R11)
        for (int i = 0; i < 300; i++) begin
            cfg_xbar_en  = ($urandom % 8) != 0;
            cfg_uart_en  = 1'($urandom);
            cfg_spi_en   = 1'($urandom);
            cfg_spi_mode = 2'($urandom);
            cfg_twi_en   = 1'($urandom);
            cfg_tmr0_en  = 1'($urandom);
            cfg_tmr1_en  = 1'($urandom);
            cfg_skip     = NP'($urandom) & NP'($urandom) & NP'($urandom);
            cfg_pushpull = NP'($urandom);
            load_cfg();
            model_map();
            check_map("R4 R5 R6 random");
        end

        finish_run();
    end

endmodule